// File: doc/BRIEF.md
# Enhanced-Speed Baud Clock Selector

This block sits next to an asynchronous serial controller on an 8-bit host bus. It decodes one 256-byte I/O page, whose base a strap input places at either 0xDE00 or 0xDF00. It produces the controller's chip-select for the four controller offsets. It also adds one register of its own at offset 7, the speed register, and drives that register's read-data path.

The block watches host writes to the controller's control register at offset 3. When the low four bits of the last such write are all zero, the block enters enhanced mode. In enhanced mode it replaces the controller's internal rate generator with the reference oscillator, passed through directly or divided by 2 or by 4. Two writable bits in the speed register choose the divide ratio. A read-only bit in the same register reports whether enhanced mode is active.

All chip-selects are qualified by a copy of the host phi2 clock. That copy is delayed by a set number of fast-clock cycles so that the controller's bus timing is met. The divider is a free-running counter, so a change of ratio never restarts it.

Top module: `es_baud_sel`

## Requirements
- R1: The strap `page_sel` picks the decoded page: 0 selects 0xDE00 to 0xDEFF and 1 selects 0xDF00 to 0xDFFF. An access to the other page asserts no chip-select and changes no state.
- R2: `ser_cs` is high for offsets 0 to 3 of the selected page, and only while the delayed phi2 is high. `es_cs` is high for offset 7 under the same qualification. No other offset asserts either select.
- R3: A read of offset 7 asserts `es_oe` and drives `es_rdata` = {5'b0, mode bit, rate[1:0]}. Bit 2 is the mode bit and bits 1:0 are the rate code.
- R4: Bits 7:3 of `es_rdata` always read 0, whatever value was written to them.
- R5: The mode bit is 1 exactly when bits 3:0 of the most recent write to offset 3 were all zero. Bits 7:4 of that write have no effect.
- R6: A write to offset 7 loads the rate code from bits 1:0. Bit 2 is read-only, and writing it has no effect.
- R7: With the mode bit at 0, `baud_clk` follows the oscillator. With the mode bit at 1, `baud_clk` is the oscillator divided by 1 for rate code 00, by 2 for code 01, and by 4 for code 10 and for code 11.
- R8: Reset clears the mode bit to 0 and the rate code to 00.
- R9: A chip-select rises `PHI2_DLY` fast-clock cycles after phi2 rises.
- R10: `enh_mode` always equals the mode bit that a read of offset 7 returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator, also the fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_sel | input | 1 | Page strap: 0 selects 0xDE, 1 selects 0xDF |
| phi2 | input | 1 | Host bus phase-2 clock |
| bus_addr | input | 16 | Host address |
| bus_rw | input | 1 | 1 for a read, 0 for a write |
| bus_wdata | input | 8 | Host write data |
| ser_cs | output | 1 | Chip-select for the serial controller, offsets 0 to 3 |
| es_cs | output | 1 | Chip-select for the speed register, offset 7 |
| es_oe | output | 1 | Read-data enable for offset 7 |
| es_rdata | output | 8 | Speed register read data |
| enh_mode | output | 1 | Enhanced mode active; controller uses baud_clk in place of its own generator |
| baud_clk | output | 1 | Rate clock for the controller |

## Verification
Each bus cycle in the vector table is checked for both chip-selects and for the read-back value. The table mixes control writes whose low nibble is zero with control writes whose low nibble is nonzero, which separates a snoop of the low nibble from one of the whole byte. It also includes writes to offset 7 with the high bits and bit 2 set, which shows whether those bits are stored, and accesses to the page that is not strapped, under both strap settings, which shows whether the page strap is obeyed. The clock output is checked by counting its transitions over a fixed window for each of the four rate codes, and once with enhanced mode off. These counts separate divide by 1, by 2 and by 4, and show that code 11 falls back to divide by 4. Directed tests also measure the cycle in which the select rises after phi2 rises, and check that a reset in the middle of a run clears both fields.

// File: rtl/es_baud_pkg.sv
package es_baud_pkg;

   // Rate code held in bits 1:0 of the speed register
   typedef enum logic [1:0] {
      RATE_FULL    = 2'b00,
      RATE_HALF    = 2'b01,
      RATE_QUARTER = 2'b10,
      RATE_RSVD    = 2'b11
   } rate_e;

   typedef struct packed {
      logic  enh;
      rate_e rate;
   } es_state_t;

   localparam es_state_t ES_RESET = '{enh: 1'b0, rate: RATE_FULL};

   // Maps a rate code to a tap of the divider chain (0 = undivided).
   // The undefined code falls back to the slowest available tap.
   function automatic int unsigned rate_tap(rate_e r, int unsigned max_tap);
      int unsigned t;
      case (r)
         RATE_FULL:    t = 0;
         RATE_HALF:    t = 1;
         RATE_QUARTER: t = 2;
         default:      t = 2;
      endcase
      if (t > max_tap) t = max_tap;
      return t;
   endfunction

endpackage

// File: rtl/es_phi2_delay.sv
module es_phi2_delay #(
   parameter int unsigned DLY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phi2,
   output logic phi2_dly
);

   generate
      if (DLY == 0) begin : g_bypass
         assign phi2_dly = phi2;
      end else begin : g_shift
         logic [DLY-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (DLY == 1) sh_q <= phi2;
            else sh_q <= {sh_q[DLY-2:0], phi2};
         end
         assign phi2_dly = sh_q[DLY-1];
      end
   endgenerate

endmodule

// File: rtl/es_addr_decode.sv
module es_addr_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned OFF_W     = 8,
   parameter logic [7:0]  PAGE_A    = 8'hDE,
   parameter logic [7:0]  PAGE_B    = 8'hDF,
   parameter int unsigned SER_SPAN  = 4,
   parameter int unsigned CTL_OFF   = 3,
   parameter int unsigned ES_OFF    = 7
) (
   input  logic              page_sel,
   input  logic              phi2_dly,
   input  logic [ADDR_W-1:0] addr,
   output logic              ctl_hit,
   output logic              es_hit,
   output logic              ser_cs,
   output logic              es_cs
);

   localparam int unsigned HI_W = ADDR_W - OFF_W;

   logic [HI_W-1:0]  page_hi;
   logic [OFF_W-1:0] offset;
   logic [HI_W-1:0]  want_page;
   logic             page_hit;
   logic             ser_hit;

   assign page_hi   = addr[ADDR_W-1:OFF_W];
   assign offset    = addr[OFF_W-1:0];
   assign want_page = page_sel ? HI_W'(PAGE_B) : HI_W'(PAGE_A);
   assign page_hit  = (page_hi == want_page);

   assign ser_hit = page_hit && (offset < OFF_W'(SER_SPAN));
   assign ctl_hit = page_hit && (offset == OFF_W'(CTL_OFF));
   assign es_hit  = page_hit && (offset == OFF_W'(ES_OFF));

   assign ser_cs = phi2_dly && ser_hit;
   assign es_cs  = phi2_dly && es_hit;

endmodule

// File: rtl/es_mode_reg.sv
module es_mode_reg
   import es_baud_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NIB_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2_dly,
   input  logic              ctl_hit,
   input  logic              es_hit,
   input  logic              bus_rw,
   input  logic [DATA_W-1:0] wdata,
   output es_state_t         state
);

   logic      phi2_q;
   logic      cyc_end;
   es_state_t st_q;

   // A write is taken as the qualified phase ends, when data is settled
   assign cyc_end = phi2_q && !phi2_dly;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phi2_q <= 1'b0;
         st_q   <= ES_RESET;
      end else begin
         phi2_q <= phi2_dly;
         if (cyc_end && !bus_rw) begin
            if (ctl_hit) st_q.enh  <= (wdata[NIB_W-1:0] == '0);
            if (es_hit)  st_q.rate <= rate_e'(wdata[1:0]);
         end
      end
   end

   assign state = st_q;

endmodule

// File: rtl/es_clk_div_mux.sv
module es_clk_div_mux
   import es_baud_pkg::*;
#(
   parameter int unsigned DIV_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enh,
   input  rate_e rate,
   output logic  baud_clk
);

   localparam int unsigned NTAP = DIV_STAGES + 1;

   logic [DIV_STAGES-1:0] cnt_q;
   logic [NTAP-1:0]       taps;
   int unsigned           sel;

   // Free-running: ratio changes never restart the count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign taps[0] = clk;
   generate
      for (genvar i = 1; i < NTAP; i++) begin : g_tap
         assign taps[i] = cnt_q[i-1];
      end
   endgenerate

   assign sel = rate_tap(rate, DIV_STAGES);

   always_comb begin
      baud_clk = clk;
      if (enh) baud_clk = taps[sel];
   end

endmodule

// File: rtl/es_baud_sel.sv
module es_baud_sel
   import es_baud_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned OFF_W      = 8,
   parameter logic [7:0]  PAGE_A     = 8'hDE,
   parameter logic [7:0]  PAGE_B     = 8'hDF,
   parameter int unsigned SER_SPAN   = 4,
   parameter int unsigned CTL_OFF    = 3,
   parameter int unsigned ES_OFF     = 7,
   parameter int unsigned PHI2_DLY   = 3,
   parameter int unsigned DIV_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_sel,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rw,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              ser_cs,
   output logic              es_cs,
   output logic              es_oe,
   output logic [DATA_W-1:0] es_rdata,
   output logic              enh_mode,
   output logic              baud_clk
);

   localparam int unsigned FIELD_W = 3;

   generate
      if (ADDR_W <= OFF_W) begin : g_chk_addr
         $error("ADDR_W must exceed OFF_W");
      end
      if (DATA_W < FIELD_W + 1) begin : g_chk_data
         $error("DATA_W too narrow for the speed register");
      end
      if (CTL_OFF >= SER_SPAN) begin : g_chk_ctl
         $error("CTL_OFF must fall inside the controller span");
      end
      if (ES_OFF < SER_SPAN) begin : g_chk_es
         $error("ES_OFF must lie outside the controller span");
      end
      if (DIV_STAGES < 1) begin : g_chk_div
         $error("DIV_STAGES must be at least 1");
      end
   endgenerate

   logic      phi2_dly;
   logic      ctl_hit;
   logic      es_hit;
   es_state_t state;

   es_phi2_delay #(.DLY(PHI2_DLY)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi2     (phi2),
      .phi2_dly (phi2_dly)
   );

   es_addr_decode #(
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .PAGE_A   (PAGE_A),
      .PAGE_B   (PAGE_B),
      .SER_SPAN (SER_SPAN),
      .CTL_OFF  (CTL_OFF),
      .ES_OFF   (ES_OFF)
   ) u_dec (
      .page_sel (page_sel),
      .phi2_dly (phi2_dly),
      .addr     (bus_addr),
      .ctl_hit  (ctl_hit),
      .es_hit   (es_hit),
      .ser_cs   (ser_cs),
      .es_cs    (es_cs)
   );

   es_mode_reg #(.DATA_W(DATA_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi2_dly (phi2_dly),
      .ctl_hit  (ctl_hit),
      .es_hit   (es_hit),
      .bus_rw   (bus_rw),
      .wdata    (bus_wdata),
      .state    (state)
   );

   es_clk_div_mux #(.DIV_STAGES(DIV_STAGES)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .enh      (state.enh),
      .rate     (state.rate),
      .baud_clk (baud_clk)
   );

   assign es_oe    = es_cs && bus_rw;
   assign es_rdata = {{(DATA_W-FIELD_W){1'b0}}, state.enh, state.rate};
   assign enh_mode = state.enh;

endmodule

// File: rtl/es_baud_sel_chk.sv
module es_baud_sel_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_cs,
   input logic              es_cs,
   input logic              es_oe,
   input logic [DATA_W-1:0] es_rdata,
   input logic              enh_mode
);

   // R2
   cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_cs && es_cs));

   // R4
   rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      es_rdata[DATA_W-1:3] == '0);

   // R8
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (es_rdata[2:0] == 3'b000 && !enh_mode));

   // R10
   oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      es_oe |-> (es_rdata[2] == enh_mode));

   // R5
   mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(enh_mode) |-> !ser_cs);

   // R3
   oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      es_oe |-> es_cs);

endmodule

bind es_baud_sel es_baud_sel_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_cs   (ser_cs),
   .es_cs    (es_cs),
   .es_oe    (es_oe),
   .es_rdata (es_rdata),
   .enh_mode (enh_mode)
);

// File: tb/es_baud_sel_bench.sv
module es_baud_sel_bench;

   localparam int unsigned DLY = 3;
   localparam int unsigned NV  = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        page_sel = 1'b0;
   logic        phi2 = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_rw = 1'b1;
   logic [7:0]  bus_wdata = 8'h00;
   logic        ser_cs, es_cs, es_oe, enh_mode, baud_clk;
   logic [7:0]  es_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   es_baud_sel #(.PHI2_DLY(DLY)) u_es_baud_sel (
      .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .phi2(phi2),
      .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
      .ser_cs(ser_cs), .es_cs(es_cs), .es_oe(es_oe), .es_rdata(es_rdata),
      .enh_mode(enh_mode), .baud_clk(baud_clk)
   );

   // {page_sel, page, offset, rw, wdata, exp_ser, exp_es, exp_rdata}
   typedef logic [35:0] vec_t;
   localparam vec_t VECS [NV] = '{
      {1'b0, 8'hDE, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h00}, // R3 R8 read after reset
      {1'b0, 8'hDE, 8'h03, 1'b0, 8'h10, 1'b1, 1'b0, 8'h00}, // R5 low nibble zero
      {1'b0, 8'hDE, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h04}, // R5 mode set
      {1'b0, 8'hDE, 8'h07, 1'b0, 8'hFA, 1'b0, 1'b1, 8'h00}, // R4 R6 junk high bits
      {1'b0, 8'hDE, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h06}, // R4 R6 rate 10 only
      {1'b0, 8'hDF, 8'h07, 1'b0, 8'h01, 1'b0, 1'b0, 8'h00}, // R1 other page
      {1'b0, 8'hDE, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h06}, // R1 unchanged
      {1'b1, 8'hDF, 8'h07, 1'b0, 8'h01, 1'b0, 1'b1, 8'h00}, // R1 strap high
      {1'b1, 8'hDF, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h05}, // R6 rate 01
      {1'b1, 8'hDE, 8'h03, 1'b0, 8'h0F, 1'b0, 1'b0, 8'h00}, // R1 other page ctl
      {1'b1, 8'hDF, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h05}, // R1 mode kept
      {1'b1, 8'hDF, 8'h03, 1'b0, 8'h1E, 1'b1, 1'b0, 8'h00}, // R5 nonzero nibble
      {1'b1, 8'hDF, 8'h07, 1'b1, 8'h00, 1'b0, 1'b1, 8'h01}, // R5 mode cleared
      {1'b1, 8'hDF, 8'h05, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00}, // R2 offset 5 unused
      {1'b1, 8'hDF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00}  // R2 offset 0
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_cycle(input logic ps, input logic [7:0] pg, input logic [7:0] off,
                            input logic rw, input logic [7:0] wd,
                            output logic g_ser, output logic g_es, output logic g_oe,
                            output logic [7:0] g_rd);
      @(negedge clk);
      page_sel  = ps;
      bus_addr  = {pg, off};
      bus_rw    = rw;
      bus_wdata = wd;
      phi2      = 1'b1;
      repeat (DLY + 2) @(negedge clk);
      g_ser = ser_cs; g_es = es_cs; g_oe = es_oe; g_rd = es_rdata;
      phi2 = 1'b0;
      repeat (DLY + 3) @(negedge clk);
      bus_rw = 1'b1;
   endtask

   task automatic count_edges(output int n);
      logic prev;
      n = 0;
      @(posedge clk); #2 prev = baud_clk;
      for (int i = 0; i < 33; i++) begin
         if (i % 2 == 0) begin @(negedge clk); #2; end
         else begin @(posedge clk); #2; end
         if (baud_clk !== prev) n++;
         prev = baud_clk;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic s, e, o;
      logic [7:0] rd;
      int n;
      repeat (3) @(negedge clk);
      // R8 reset state
      check(!ser_cs && !es_cs && !enh_mode && es_rdata == 8'h00, "R8", es_rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v = VECS[i];
         bus_cycle(v[35], v[34:27], v[26:19], v[18], v[17:10], s, e, o, rd);
         check(s == v[9], "R2 ser_cs", s, v[9]);
         check(e == v[8], "R2 es_cs", e, v[8]);
         check(o == (v[8] && v[18]), "R3 es_oe", o, v[8] && v[18]);
         if (v[8] && v[18]) check(rd == v[7:0], "R3 rdata", rd, v[7:0]);
         if (v[8] && v[18]) check(enh_mode == rd[2], "R10 enh_mode", enh_mode, rd[2]);
      end

      // R9 select timing after phi2 rise
      @(negedge clk);
      page_sel = 1'b0; bus_addr = 16'hDE01; bus_rw = 1'b1; phi2 = 1'b1;
      repeat (DLY - 1) @(negedge clk);
      check(!ser_cs, "R9 early", ser_cs, 0);
      @(negedge clk);
      check(ser_cs, "R9 on time", ser_cs, 1);
      phi2 = 1'b0;
      repeat (DLY + 3) @(negedge clk);

      // R7 clock rates: enhanced off with rate 01 set
      bus_cycle(1'b0, 8'hDE, 8'h07, 1'b0, 8'h01, s, e, o, rd);
      count_edges(n);
      check(n == 33 && !enh_mode, "R7 standard", n, 33);
      bus_cycle(1'b0, 8'hDE, 8'h03, 1'b0, 8'hA0, s, e, o, rd);
      check(enh_mode, "R10 enh on", enh_mode, 1);
      count_edges(n);
      check(n == 16, "R7 div2", n, 16);
      bus_cycle(1'b0, 8'hDE, 8'h07, 1'b0, 8'h00, s, e, o, rd);
      count_edges(n);
      check(n == 33, "R7 div1", n, 33);
      bus_cycle(1'b0, 8'hDE, 8'h07, 1'b0, 8'h02, s, e, o, rd);
      count_edges(n);
      check(n == 8, "R7 div4", n, 8);
      bus_cycle(1'b0, 8'hDE, 8'h07, 1'b0, 8'h03, s, e, o, rd);
      count_edges(n);
      check(n == 8, "R7 code11 div4", n, 8);

      // R8 reset mid-run clears both fields
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_cycle(1'b0, 8'hDE, 8'h07, 1'b1, 8'h00, s, e, o, rd);
      check(rd == 8'h00 && !enh_mode, "R8 mid-run", rd, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule